// File: doc/BRIEF.md
# Addend-Driven Precision Time Counter

This block keeps a 64-bit system time counted in ticks of 32 ns. A 32-bit phase accumulator adds a programmable rate word on every reference clock. Each carry out of that add moves the time forward by one tick. Software trims the clock rate in fine steps by rewriting the rate word. With a 50 MHz reference and the nominal rate word 0xA0000000, carries happen five times in every eight clocks. That gives 31.25 million ticks per second, one tick per 32 ns. Software turns ticks into nanoseconds by shifting left by 5, and back by shifting right by 5.

The block is controlled through a word-wide register port. Reads have one cycle of latency. The 64-bit time is loaded coherently: a low-half write waits in a shadow register, and the high-half write loads both halves in one cycle. A low-half read freezes the high half, so the pair read back is consistent. A soft-reset bit holds the time logic cleared. A wrap limit, writable only while its unlock bit is set, bounds the low half before it carries into the high half. A 64-bit goal time makes a one-cycle hit pulse for the neighbouring capture logic when the running time first reaches it.

Top module: `prec_time_counter`

## Requirements
- R1: After hardware reset the registers read: control 0, rate 0xA0000000, goal low 1, goal high 0, wrap unlock 0, wrap limit 0xFFFFFFFF; the time starts at 0.
- R2: Each reference clock adds the rate word to a 32-bit accumulator that starts at zero, and each carry out adds one tick. After n clocks at a constant rate A, the time is floor(n*A/2^32); for the default rate this is 5 ticks per 8 clocks.
- R3: A rate write takes effect on the clock after its write edge. A rate of 0 freezes the time.
- R4: A write to the time-low register (word address 2) only fills a shadow register, and the time does not change because of it. A write to the time-high register (word address 3) loads {written value, shadow} into the time on its write edge. This load replaces any tick in that same cycle.
- R5: A read of time-low returns the low half and captures the high half. A read of time-high returns that captured value, not the live high half.
- R6: Bit 0 of the control register (word address 0) is a soft reset. While it is 1, the time and the accumulator are held at zero. After it is cleared, counting restarts with the same phase as after a hardware reset.
- R7: A write to the wrap-limit register (word address 7) is ignored unless the wrap-unlock register (word address 6) holds 1.
- R8: A tick while the low half is at or above the wrap limit sets the low half to 0 and adds one to the high half.
- R9: When the time first becomes equal to or greater than the 64-bit goal (word addresses 4 low, 5 high), target_hit is 1 for exactly one cycle. It does not pulse again until the time has dropped below the goal and reached it again.
- R10: Register word addresses are: 0 control, 1 rate, 2 time low, 3 time high, 4 goal low, 5 goal high, 6 wrap unlock, 7 wrap limit. Read data appears on reg_rdata one clock after reg_rd is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| sys_time | output | 64 | Running system time in ticks |
| target_hit | output | 1 | One-cycle pulse when the goal time is reached |

## Verification
The assertions assume one register access per cycle, so a write and a read never share a cycle. They also assume that a time-high write is the only way the time jumps other than by a single tick or a wrap. The stimulus only drives one strobe at a time, from tasks that hold it for a single clock. Time loads are always issued low half first, then high half. The wrap limit is kept nonzero.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    localparam int ADDR_W   = 3;
    localparam int NUM_REGS = 1 << ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL     = 3'd0,
        REG_RATE     = 3'd1,
        REG_TIME_LO  = 3'd2,
        REG_TIME_HI  = 3'd3,
        REG_GOAL_LO  = 3'd4,
        REG_GOAL_HI  = 3'd5,
        REG_WRAP_EN  = 3'd6,
        REG_WRAP_LIM = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/ptc_phase_acc.sv
module ptc_phase_acc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst_i,
    input  logic [W-1:0] addend_i,
    output logic         tick_o
);

    typedef struct packed {
        logic [W-1:0] acc;
    } acc_state_t;

    acc_state_t  st_d, st_q;
    logic [W:0]  sum;

    always_comb begin
        st_d   = st_q;
        sum    = {1'b0, st_q.acc} + {1'b0, addend_i};
        tick_o = sum[W] & ~srst_i;
        if (srst_i) begin
            st_d.acc = '0;
        end else begin
            st_d.acc = sum[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (st_q.acc == '0));  // R6

    AST_ZERO_RATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst_i && addend_i == '0) |=> $stable(st_q.acc));  // R3

endmodule

// File: rtl/ptc_time_core.sv
module ptc_time_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           srst_i,
    input  logic           tick_i,
    input  logic           wr_lo_i,
    input  logic           wr_hi_i,
    input  logic [W-1:0]   wdata_i,
    input  logic [W-1:0]   wrap_lim_i,
    output logic [2*W-1:0] time_o
);

    localparam int TW = 2 * W;

    typedef struct packed {
        logic [W-1:0]  shadow;
        logic [TW-1:0] tval;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        at_limit;

    always_comb begin
        st_d     = st_q;
        at_limit = (st_q.tval[W-1:0] >= wrap_lim_i);
        if (wr_lo_i) begin
            st_d.shadow = wdata_i;
        end
        if (srst_i) begin
            st_d.tval = '0;
        end else if (wr_hi_i) begin
            st_d.tval = {wdata_i, st_q.shadow};
        end else if (tick_i) begin
            if (at_limit) begin
                st_d.tval = {st_q.tval[TW-1:W] + W'(1), W'(0)};
            end else begin
                st_d.tval = st_q.tval + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign time_o = st_q.tval;

    AST_SOFT_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (time_o == '0));  // R6

    AST_COHERENT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi_i && !srst_i) |=> (time_o == {$past(wdata_i), $past(st_q.shadow)}));  // R4

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst_i && !wr_hi_i) |=> ((time_o == $past(time_o)) ||
                                   (time_o == $past(time_o) + TW'(1)) ||
                                   (time_o == {$past(time_o[TW-1:W]) + W'(1), W'(0)})));  // R2

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !srst_i && !wr_hi_i && time_o[W-1:0] >= wrap_lim_i)
            |=> (time_o[W-1:0] == '0));  // R8

endmodule

// File: rtl/ptc_target_cmp.sv
module ptc_target_cmp #(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] time_i,
    input  logic [TW-1:0] goal_i,
    output logic          hit_o
);

    typedef struct packed {
        logic reached;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       ge_now;

    always_comb begin
        st_d         = st_q;
        ge_now       = (time_i >= goal_i);
        st_d.reached = ge_now;
        hit_o        = ge_now & ~st_q.reached;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);  // R9

endmodule

// File: rtl/prec_time_counter.sv
module prec_time_counter #(
    parameter int                       WORD_W   = 32,
    parameter logic [WORD_W-1:0]        RATE_RST = 32'hA000_0000,
    parameter logic [WORD_W-1:0]        WRAP_RST = '1,
    parameter logic [2*WORD_W-1:0]      GOAL_RST = 64'd1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [ptc_pkg::ADDR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]           reg_wdata,
    output logic [WORD_W-1:0]           reg_rdata,
    output logic [2*WORD_W-1:0]         sys_time,
    output logic                        target_hit
);

    import ptc_pkg::*;

    localparam int TW = 2 * WORD_W;

    typedef struct packed {
        logic              soft_rst;
        logic [WORD_W-1:0] rate;
        logic [TW-1:0]     goal;
        logic              wrap_en;
        logic [WORD_W-1:0] wrap_lim;
        logic [WORD_W-1:0] hi_snap;
        logic [WORD_W-1:0] rdata;
    } regs_t;

    localparam regs_t REGS_RST = '{
        soft_rst: 1'b0,
        rate:     RATE_RST,
        goal:     GOAL_RST,
        wrap_en:  1'b0,
        wrap_lim: WRAP_RST,
        hi_snap:  '0,
        rdata:    '0
    };

    regs_t               rg_d, rg_q;
    logic [NUM_REGS-1:0] wr_sel;
    logic                tick;
    logic [TW-1:0]       time_now;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_wr_dec
        assign wr_sel[g] = reg_wr && (reg_addr == ADDR_W'(g));
    end

    always_comb begin
        rg_d = rg_q;
        if (wr_sel[REG_CTRL]) begin
            rg_d.soft_rst = reg_wdata[0];
        end
        if (wr_sel[REG_RATE]) begin
            rg_d.rate = reg_wdata;
        end
        if (wr_sel[REG_GOAL_LO]) begin
            rg_d.goal[WORD_W-1:0] = reg_wdata;
        end
        if (wr_sel[REG_GOAL_HI]) begin
            rg_d.goal[TW-1:WORD_W] = reg_wdata;
        end
        if (wr_sel[REG_WRAP_EN]) begin
            rg_d.wrap_en = reg_wdata[0];
        end
        if (wr_sel[REG_WRAP_LIM] && rg_q.wrap_en) begin
            rg_d.wrap_lim = reg_wdata;
        end
        if (reg_rd) begin
            case (reg_sel_e'(reg_addr))
                REG_CTRL:     rg_d.rdata = {{(WORD_W-1){1'b0}}, rg_q.soft_rst};
                REG_RATE:     rg_d.rdata = rg_q.rate;
                REG_TIME_LO: begin
                    rg_d.rdata   = time_now[WORD_W-1:0];
                    rg_d.hi_snap = time_now[TW-1:WORD_W];
                end
                REG_TIME_HI:  rg_d.rdata = rg_q.hi_snap;
                REG_GOAL_LO:  rg_d.rdata = rg_q.goal[WORD_W-1:0];
                REG_GOAL_HI:  rg_d.rdata = rg_q.goal[TW-1:WORD_W];
                REG_WRAP_EN:  rg_d.rdata = {{(WORD_W-1){1'b0}}, rg_q.wrap_en};
                REG_WRAP_LIM: rg_d.rdata = rg_q.wrap_lim;
                default:      rg_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= REGS_RST;
        end else begin
            rg_q <= rg_d;
        end
    end

    ptc_phase_acc #(.W(WORD_W)) i_phase_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst_i   (rg_q.soft_rst),
        .addend_i (rg_q.rate),
        .tick_o   (tick)
    );

    ptc_time_core #(.W(WORD_W)) i_time_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst_i     (rg_q.soft_rst),
        .tick_i     (tick),
        .wr_lo_i    (wr_sel[REG_TIME_LO]),
        .wr_hi_i    (wr_sel[REG_TIME_HI]),
        .wdata_i    (reg_wdata),
        .wrap_lim_i (rg_q.wrap_lim),
        .time_o     (time_now)
    );

    ptc_target_cmp #(.TW(TW)) i_target_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .time_i (time_now),
        .goal_i (rg_q.goal),
        .hit_o  (target_hit)
    );

    assign sys_time  = time_now;
    assign reg_rdata = rg_q.rdata;

    AST_WRAP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[REG_WRAP_LIM] && !rg_q.wrap_en) |=> $stable(rg_q.wrap_lim));  // R7

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == REG_RATE && !reg_wr) |=> (reg_rdata == $past(rg_q.rate)));  // R10

endmodule

// File: tb/test_prec_time_counter.sv
module test_prec_time_counter;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] A_CTRL = 3'd0, A_RATE = 3'd1, A_TLO = 3'd2, A_THI = 3'd3,
                           A_GLO = 3'd4, A_GHI = 3'd5, A_WEN = 3'd6, A_WLIM = 3'd7;

    // {rate, clocks after soft reset release, expected ticks = floor(clocks*rate/2^32)}
    localparam logic [95:0] VEC [0:7] = '{
        {32'hA000_0000, 32'd8,  32'd5},
        {32'hA000_0000, 32'd16, 32'd10},
        {32'h8000_0000, 32'd10, 32'd5},
        {32'hFFFF_FFFF, 32'd20, 32'd19},
        {32'h0000_0000, 32'd12, 32'd0},
        {32'h4000_0000, 32'd9,  32'd2},
        {32'hA000_0000, 32'd1,  32'd0},
        {32'hA000_0000, 32'd2,  32'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] sys_time;
    logic        target_hit;

    int checks = 0;
    int failures = 0;
    int hit_cnt = 0;
    logic [31:0] rv;
    int hit_base;

    always #(CLK_PERIOD/2) clk = ~clk;

    prec_time_counter i_prec_time_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .sys_time   (sys_time),
        .target_hit (target_hit)
    );

    always @(negedge clk) begin
        if (rst_n && target_hit) hit_cnt <= hit_cnt + 1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic restart(input logic [31:0] rate);
        wr(A_CTRL, 32'd1);
        wr(A_RATE, rate);
        wr(A_CTRL, 32'd0);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 time at reset", sys_time, 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 default rate 5 clocks", sys_time, 64'd3);
        chk("R9 hit after reset goal 1", 64'(hit_cnt), 64'd1);

        rd(A_CTRL, rv);   chk("R1 R10 control", 64'(rv), 64'd0);
        rd(A_RATE, rv);   chk("R1 R10 rate", 64'(rv), 64'hA000_0000);
        rd(A_GLO, rv);    chk("R1 R10 goal low", 64'(rv), 64'd1);
        rd(A_GHI, rv);    chk("R1 R10 goal high", 64'(rv), 64'd0);
        rd(A_WEN, rv);    chk("R1 R10 wrap unlock", 64'(rv), 64'd0);
        rd(A_WLIM, rv);   chk("R1 R10 wrap limit", 64'(rv), 64'hFFFF_FFFF);

        for (int i = 0; i < 8; i++) begin
            restart(VEC[i][95:64]);
            repeat (int'(VEC[i][63:32])) @(negedge clk);
            chk($sformatf("R2 vector %0d", i), sys_time, 64'(VEC[i][31:0]));
        end

        // R6: soft reset holds zero, reads back as 1
        restart(32'hA000_0000);
        repeat (6) @(negedge clk);
        wr(A_CTRL, 32'd1);
        repeat (10) @(negedge clk);
        chk("R6 held at zero", sys_time, 64'd0);
        rd(A_CTRL, rv);   chk("R6 control bit", 64'(rv), 64'd1);
        wr(A_CTRL, 32'd0);
        repeat (2) @(negedge clk);
        chk("R6 restart phase", sys_time, 64'd1);

        // R3: rate change applies from the next clock
        restart(32'h8000_0000);
        repeat (4) @(negedge clk);
        wr(A_RATE, 32'd0);
        repeat (10) @(negedge clk);
        chk("R3 zero rate freezes", sys_time, 64'd2);
        wr(A_RATE, 32'h8000_0000);
        chk("R3 write edge uses old rate", sys_time, 64'd2);
        @(negedge clk);
        chk("R3 new rate next clock", sys_time, 64'd3);

        // R4: coherent load
        restart(32'hFFFF_FFFF);
        repeat (2) @(negedge clk);
        wr(A_TLO, 32'h1111_1111);
        chk("R4 low write only shadowed", sys_time, 64'd2);
        wr(A_THI, 32'h2222_2222);
        chk("R4 high write loads both", sys_time, 64'h2222_2222_1111_1111);
        @(negedge clk);
        chk("R4 counting resumes", sys_time, 64'h2222_2222_1111_1112);

        // R5: high half snapshot on low read
        wr(A_TLO, 32'hFFFF_FFFF);
        wr(A_THI, 32'h0000_0007);
        rd(A_TLO, rv);    chk("R5 low read", 64'(rv), 64'hFFFF_FFFF);
        rd(A_THI, rv);    chk("R5 high read is snapshot", 64'(rv), 64'd7);
        chk("R5 live time moved on", sys_time, 64'h0000_0008_0000_0001);

        // R7: wrap limit gated by unlock
        wr(A_WLIM, 32'd5);
        rd(A_WLIM, rv);   chk("R7 locked write ignored", 64'(rv), 64'hFFFF_FFFF);
        wr(A_WEN, 32'd1);
        wr(A_WLIM, 32'd5);
        wr(A_WEN, 32'd0);
        rd(A_WLIM, rv);   chk("R7 unlocked write taken", 64'(rv), 64'd5);

        // R8: low half wraps at the limit
        wr(A_TLO, 32'd3);
        wr(A_THI, 32'h10);
        repeat (2) @(negedge clk);
        chk("R8 reaches limit", sys_time, 64'h0000_0010_0000_0005);
        @(negedge clk);
        chk("R8 wraps into high", sys_time, 64'h0000_0011_0000_0000);
        wr(A_WEN, 32'd1);
        wr(A_WLIM, 32'hFFFF_FFFF);
        wr(A_WEN, 32'd0);

        // R9: goal pulse once, re-arms after time drops below
        restart(32'd0);
        wr(A_CTRL, 32'd1);
        wr(A_GLO, 32'h100);
        wr(A_GHI, 32'd0);
        wr(A_CTRL, 32'd0);
        hit_base = hit_cnt;
        wr(A_TLO, 32'hFD);
        wr(A_THI, 32'd0);
        wr(A_RATE, 32'hFFFF_FFFF);
        repeat (10) @(negedge clk);
        chk("R9 single pulse at goal", 64'(hit_cnt - hit_base), 64'd1);
        chk("R9 time past goal", 64'(sys_time >= 64'h100), 64'd1);
        wr(A_TLO, 32'd0);
        wr(A_THI, 32'd0);
        repeat (300) @(negedge clk);
        chk("R9 re-armed pulse", 64'(hit_cnt - hit_base), 64'd2);

        summary();
    end

endmodule